// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter connects a CPU-side port that issues big-endian byte, halfword and word accesses to a register file whose registers are not all the same width. For every 4-byte group of the register space, a width table tells the adapter whether the registers there are byte, halfword or word wide, or unimplemented. The adapter then runs each host access as a short sequence of accesses at the native width: wide host accesses are split into ascending native pieces, narrow reads pull out one lane of the enclosing register, and narrow writes become a read-merge-write of that register.

The host raises `req_valid` for one cycle while the adapter is idle. The register-file port then carries one native access per cycle, and a one-cycle `rsp_ready` pulse marks the end of the composite access. Offsets in the upper half of the decoded window are refused: they complete at once with an error and never reach the register file. The width table sits outside the block and is read combinationally through `wt_idx` and `wt_code`.

Top module: `regacc_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the offset. Upper address bits have no effect on which registers are accessed or on the data returned.
- R2: An offset of 0x200 or above completes with `rsp_ready` and `rsp_err` high in the first cycle after acceptance. `rsp_rdata` is 0 and no register-file access takes place.
- R3: `wt_idx` is offset bits 9:2. The table code is 0 for unimplemented, 1 for byte, 2 for halfword and 3 for word. Every register-file access uses the native size, with `rf_size` 0, 1 or 2 for 1, 2 or 4 bytes and unimplemented treated as byte, and its address is aligned to that size.
- R4: A read of S bytes at offset A returns bytes A to A+S-1 in big-endian order. The lowest address is the most significant byte, the result is right-justified in `rsp_rdata`, and bits above S bytes are 0. A byte read at an even address of a halfword register therefore returns the upper byte.
- R5: An access of S bytes to registers of native width W with W ≤ S is issued as S/W native accesses, one per cycle, at ascending addresses. The most significant data goes to the lowest address.
- R6: A read narrower than the native width issues exactly one native read of the enclosing register.
- R7: A write narrower than the native width issues one native read and then one native write of the enclosing register. That write replaces only the addressed bytes and keeps all the others.
- R8: `busy` is high from the cycle after acceptance until the cycle of `rsp_ready`. `rsp_ready` is a single-cycle pulse in the cycle after the last native access, so the latency is N+1 cycles for N native accesses.
- R9: After reset the adapter is idle: `busy`, `rsp_ready` and `rf_en` are low.
- R10: Address bits below the access size are ignored. A halfword access uses the offset with bit 0 cleared, and a word access uses the offset with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access; accepted only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Composite access in progress |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an out-of-range offset |
| rsp_rdata | output | 32 | Read result, right-justified, valid with rsp_ready |
| wt_idx | output | 8 | Width-table index (offset bits 9:2) |
| wt_code | input | 2 | Width-table code for wt_idx |
| rf_en | output | 1 | Native register-file access this cycle |
| rf_we | output | 1 | Native access is a write |
| rf_size | output | 2 | Native size, log2 of bytes |
| rf_addr | output | 10 | Native byte offset |
| rf_wdata | output | 32 | Native write data, right-justified |
| rf_rdata | input | 32 | Native read data, right-justified, same cycle |

## Verification
The hardest case to reach is a narrow write into a word register. It is only visible from the ports if the other byte lanes come through unchanged and the read comes before the write on the register-file port. The bench sweeps every group of the space, with a width table computed from the index so that every native width and the unimplemented code all occur. In each group it writes every size at every aligned offset. After each write it compares the whole group against a byte-level shadow, and it reads back every size, using aliased upper address bits and stray low bits. A monitor on the register-file port counts the native accesses, checks their size and alignment, and logs their read/write order against the count worked out from the table.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_RDM,
    ST_WRM,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/regacc_plan.sv
// Decodes a new host request against the width table.
module regacc_plan #(
  parameter int OFF_W     = 10,
  parameter int ERR_LIMIT = 512
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size_code,
  input  logic [1:0]       wt_code,
  output logic             bad,
  output logic             narrow,
  output logic [1:0]       slog,
  output logic [1:0]       wlog,
  output logic [1:0]       nsub_m1,
  output logic [OFF_W-1:0] base_off
);
  logic [1:0] diff;

  always_comb begin
    case (size_code)
      2'd0:    slog = 2'd0;
      2'd1:    slog = 2'd1;
      default: slog = 2'd2;
    endcase
    case (wt_code)
      2'd3:    wlog = 2'd2;
      2'd2:    wlog = 2'd1;
      default: wlog = 2'd0;
    endcase
    narrow   = slog < wlog;
    diff     = slog - wlog;
    case (diff)
      2'd2:    nsub_m1 = 2'd3;
      2'd1:    nsub_m1 = 2'd1;
      default: nsub_m1 = 2'd0;
    endcase
    base_off = off & ({OFF_W{1'b1}} << slog);
    bad      = 32'(off) >= 32'(ERR_LIMIT);
  end
endmodule

// File: rtl/regacc_lane.sv
// Big-endian lane extraction and merge inside one native register.
module regacc_lane (
  input  logic [31:0] native,
  input  logic [31:0] wdata,
  input  logic [1:0]  off_lo,
  input  logic [1:0]  slog,
  input  logic [1:0]  wlog,
  output logic [31:0] lane_rd,
  output logic [31:0] lane_merged
);
  logic [2:0]  wbytes, sbytes, pos, shb;
  logic [5:0]  sh;
  logic [31:0] smask;

  always_comb begin
    wbytes = 3'd1 << wlog;
    sbytes = 3'd1 << slog;
    pos    = {1'b0, off_lo} & (wbytes - 3'd1);
    shb    = wbytes - pos - sbytes;
    sh     = {shb, 3'b000};
    case (slog)
      2'd0:    smask = 32'h0000_00FF;
      2'd1:    smask = 32'h0000_FFFF;
      default: smask = 32'hFFFF_FFFF;
    endcase
    lane_rd     = (native >> sh) & smask;
    lane_merged = (native & ~(smask << sh)) | ((wdata & smask) << sh);
  end
endmodule

// File: rtl/regacc_seq.sv
// Sequencer: one native access per cycle, then a completion cycle.
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  input  logic             plan_bad,
  input  logic             plan_narrow,
  input  logic [1:0]       plan_slog,
  input  logic [1:0]       plan_wlog,
  input  logic [1:0]       plan_nsub_m1,
  input  logic [OFF_W-1:0] plan_base,
  input  logic [31:0]      lane_rd,
  input  logic [31:0]      lane_merged,
  input  logic [31:0]      rf_rdata,
  output logic             busy,
  output logic             rsp_ready,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             rf_en,
  output logic             rf_we,
  output logic [1:0]       rf_size,
  output logic [OFF_W-1:0] rf_addr,
  output logic [31:0]      rf_wdata,
  output logic [1:0]       off_lo,
  output logic [1:0]       slog_q,
  output logic [1:0]       wlog_q,
  output logic [31:0]      wdata_q
);
  seq_state_e       state, state_d;
  logic [OFF_W-1:0] off_q;
  logic             we_q, err_q;
  logic [1:0]       nsub_q, cnt, cnt_d;
  logic [31:0]      hold, hold_d;
  logic             load;
  logic [5:0]       wbits;
  logic [31:0]      wmask;
  logic [OFF_W-1:0] nat_addr;

  always_comb begin
    wbits = 6'd8 << wlog_q;
    case (wlog_q)
      2'd0:    wmask = 32'h0000_00FF;
      2'd1:    wmask = 32'h0000_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
    nat_addr = off_q & ({OFF_W{1'b1}} << wlog_q);
  end

  always_comb begin
    state_d  = state;
    hold_d   = hold;
    cnt_d    = cnt;
    load     = 1'b0;
    rf_en    = 1'b0;
    rf_we    = 1'b0;
    rf_size  = 2'd0;
    rf_addr  = '0;
    rf_wdata = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          load  = 1'b1;
          cnt_d = 2'd0;
          hold_d = (req_write && !plan_narrow) ?
                   (req_wdata << (6'd32 - (6'd8 << plan_slog))) : 32'd0;
          if (plan_bad)         state_d = ST_DONE;
          else if (plan_narrow) state_d = ST_RDM;
          else                  state_d = ST_SPLIT;
        end
      end
      ST_SPLIT: begin
        rf_en    = 1'b1;
        rf_we    = we_q;
        rf_size  = wlog_q;
        rf_addr  = off_q + (OFF_W'(cnt) << wlog_q);
        rf_wdata = hold >> (6'd32 - wbits);
        hold_d   = we_q ? (hold << wbits) : ((hold << wbits) | (rf_rdata & wmask));
        cnt_d    = cnt + 2'd1;
        if (cnt == nsub_q) state_d = ST_DONE;
      end
      ST_RDM: begin
        rf_en   = 1'b1;
        rf_size = wlog_q;
        rf_addr = nat_addr;
        hold_d  = we_q ? lane_merged : lane_rd;
        state_d = we_q ? ST_WRM : ST_DONE;
      end
      ST_WRM: begin
        rf_en    = 1'b1;
        rf_we    = 1'b1;
        rf_size  = wlog_q;
        rf_addr  = nat_addr;
        rf_wdata = hold;
        state_d  = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hold  <= '0;
      cnt   <= '0;
    end else begin
      state <= state_d;
      hold  <= hold_d;
      cnt   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      nsub_q  <= '0;
      slog_q  <= '0;
      wlog_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      off_q   <= plan_base;
      we_q    <= req_write;
      err_q   <= plan_bad;
      nsub_q  <= plan_nsub_m1;
      slog_q  <= plan_slog;
      wlog_q  <= plan_wlog;
      wdata_q <= req_wdata;
    end
  end

  assign busy      = state != ST_IDLE;
  assign rsp_ready = state == ST_DONE;
  assign rsp_err   = rsp_ready && err_q;
  assign rsp_rdata = (rsp_ready && !we_q && !err_q) ? hold : 32'd0;
  assign off_lo    = off_q[1:0];
endmodule

// File: rtl/regacc_adapter.sv
module regacc_adapter #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 10,
  parameter int ERR_LIMIT = 512,
  localparam int IDX_W    = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [IDX_W-1:0]  wt_idx,
  input  logic [1:0]        wt_code,
  output logic              rf_en,
  output logic              rf_we,
  output logic [1:0]        rf_size,
  output logic [OFF_W-1:0]  rf_addr,
  output logic [31:0]       rf_wdata,
  input  logic [31:0]       rf_rdata
);
  logic             p_bad, p_narrow;
  logic [1:0]       p_slog, p_wlog, p_nsub_m1;
  logic [OFF_W-1:0] p_base;
  logic [31:0]      lane_rd, lane_merged, wdata_q;
  logic [1:0]       off_lo, slog_q, wlog_q;
  logic             unused_hi;

  assign wt_idx    = req_addr[OFF_W-1:2];
  assign unused_hi = ^req_addr[ADDR_W-1:OFF_W];

  regacc_plan #(.OFF_W(OFF_W), .ERR_LIMIT(ERR_LIMIT)) u_plan (
    .off(req_addr[OFF_W-1:0]), .size_code(req_size), .wt_code(wt_code),
    .bad(p_bad), .narrow(p_narrow), .slog(p_slog), .wlog(p_wlog),
    .nsub_m1(p_nsub_m1), .base_off(p_base)
  );

  regacc_lane u_lane (
    .native(rf_rdata), .wdata(wdata_q), .off_lo(off_lo), .slog(slog_q),
    .wlog(wlog_q), .lane_rd(lane_rd), .lane_merged(lane_merged)
  );

  regacc_seq #(.OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .plan_bad(p_bad), .plan_narrow(p_narrow),
    .plan_slog(p_slog), .plan_wlog(p_wlog), .plan_nsub_m1(p_nsub_m1),
    .plan_base(p_base), .lane_rd(lane_rd), .lane_merged(lane_merged),
    .rf_rdata(rf_rdata), .busy(busy), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rf_en(rf_en), .rf_we(rf_we),
    .rf_size(rf_size), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .off_lo(off_lo), .slog_q(slog_q), .wlog_q(wlog_q), .wdata_q(wdata_q)
  );
endmodule

// File: rtl/regacc_chk.sv
module regacc_chk #(
  parameter int OFF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rf_en,
  input logic             rf_we,
  input logic [1:0]       rf_size,
  input logic [OFF_W-1:0] rf_addr,
  input logic             rsp_ready,
  input logic             rsp_err,
  input logic [31:0]      rsp_rdata
);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rf_en && !rsp_ready));

  a_r2_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ready && rsp_rdata == 32'd0 && !rf_en));

  a_r2_err_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !$past(busy));

  a_r3_native_align: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> ((rf_size == 2'd0) ||
               (rf_size == 2'd1 && !rf_addr[0]) ||
               (rf_size == 2'd2 && rf_addr[1:0] == 2'b00)));

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && $past(rf_en) && rf_we == $past(rf_we)) |-> rf_addr > $past(rf_addr));

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  a_r8_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !rsp_err) |-> $past(rf_en));
endmodule

bind regacc_adapter regacc_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rf_en(rf_en), .rf_we(rf_we),
  .rf_size(rf_size), .rf_addr(rf_addr), .rsp_ready(rsp_ready),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_regacc_adapter.sv
`timescale 1ns/1ps
module tb_regacc_adapter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        busy, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  wt_idx;
  logic [1:0]  wt_code;
  logic        rf_en, rf_we;
  logic [1:0]  rf_size;
  logic [9:0]  rf_addr;
  logic [31:0] rf_wdata, rf_rdata;

  int tests = 0, fails = 0;
  logic [7:0] rf_mem  [0:511];
  logic [7:0] exp_mem [0:511];
  int   sub_cnt, bad_acc;
  logic [3:0] op_log;
  logic [1:0] mon_wl;

  always #5 clk = ~clk;

  regacc_adapter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .wt_idx(wt_idx), .wt_code(wt_code),
    .rf_en(rf_en), .rf_we(rf_we), .rf_size(rf_size), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [1:0] tcode(input logic [7:0] idx);
    return idx[1:0] ^ idx[3:2];
  endfunction
  function automatic logic [1:0] wlc(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : (c == 2'd2) ? 2'd1 : 2'd0;
  endfunction

  assign wt_code = tcode(wt_idx);

  // Backing register file: big-endian, native size from rf_size.
  always_comb begin
    case (rf_size)
      2'd0: rf_rdata = {24'd0, rf_mem[rf_addr[8:0]]};
      2'd1: rf_rdata = {16'd0, rf_mem[rf_addr[8:0]], rf_mem[rf_addr[8:0] + 9'd1]};
      default: rf_rdata = {rf_mem[rf_addr[8:0]], rf_mem[rf_addr[8:0] + 9'd1],
                           rf_mem[rf_addr[8:0] + 9'd2], rf_mem[rf_addr[8:0] + 9'd3]};
    endcase
  end

  always @(posedge clk) begin
    if (rf_en && rf_we) begin
      case (rf_size)
        2'd0: rf_mem[rf_addr[8:0]] <= rf_wdata[7:0];
        2'd1: begin
          rf_mem[rf_addr[8:0]]        <= rf_wdata[15:8];
          rf_mem[rf_addr[8:0] + 9'd1] <= rf_wdata[7:0];
        end
        default: begin
          rf_mem[rf_addr[8:0]]        <= rf_wdata[31:24];
          rf_mem[rf_addr[8:0] + 9'd1] <= rf_wdata[23:16];
          rf_mem[rf_addr[8:0] + 9'd2] <= rf_wdata[15:8];
          rf_mem[rf_addr[8:0] + 9'd3] <= rf_wdata[7:0];
        end
      endcase
    end
  end

  // Port monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (rf_en) begin
      sub_cnt = sub_cnt + 1;
      op_log  = {op_log[2:0], rf_we};
      if (rf_size != mon_wl) bad_acc = bad_acc + 1;
      if ((rf_size == 2'd1 && rf_addr[0]) || (rf_size == 2'd2 && rf_addr[1:0] != 2'b00))
        bad_acc = bad_acc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
    int lat, exp_n;
    logic [1:0] sl, wl;
    logic [9:0] off;
    bit is_err, narrow, busy_seen, e_seen;
    off    = addr[9:0];
    is_err = off >= 10'h200;
    sl     = (sz >= 2'd2) ? 2'd2 : sz;
    wl     = wlc(tcode(off[9:2]));
    narrow = sl < wl;
    exp_n  = is_err ? 0 : (!narrow ? (1 << (sl - wl)) : (wr ? 2 : 1));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    sub_cnt = 0; bad_acc = 0; op_log = 4'd0; mon_wl = wl;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    lat = 1;
    while (!rsp_ready && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    e_seen = rsp_err;
    if (is_err) begin
      chk(lat == 1, "R2 latency", 32'(lat), 32'd1);
      chk(e_seen, "R2 error flag", 32'(e_seen), 32'd1);
      chk(rd == 32'd0, "R2 zero data", rd, 32'd0);
      chk(sub_cnt == 0, "R2 no access", 32'(sub_cnt), 32'd0);
    end else begin
      chk(busy_seen, "R8 busy", 32'(busy_seen), 32'd1);
      chk(lat == exp_n + 1, "R8 latency", 32'(lat), 32'(exp_n + 1));
      chk(!e_seen, "R2 no error", 32'(e_seen), 32'd0);
      chk(sub_cnt == exp_n, narrow ? (wr ? "R7 access count" : "R6 access count")
                                   : "R5 access count", 32'(sub_cnt), 32'(exp_n));
      chk(bad_acc == 0, "R3 native size/align", 32'(bad_acc), 32'd0);
      if (narrow && wr)
        chk(op_log[1:0] == 2'b01, "R7 read before write", 32'(op_log), 32'd1);
    end
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, wd, ex, addr;
    logic [9:0]  off, aoff;
    int nb;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    sub_cnt = 0; bad_acc = 0; op_log = 4'd0; mon_wl = 2'd0;
    for (int i = 0; i < 512; i++) begin
      rf_mem[i]  = 8'(i * 29 + 7);
      exp_mem[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !rsp_ready && !rf_en, "R9 reset idle",
        {29'd0, busy, rsp_ready, rf_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rsp_ready && !rf_en, "R9 idle after release",
        {29'd0, busy, rsp_ready, rf_en}, 32'd0);

    for (int g = 0; g < 128; g++) begin
      for (int sl = 0; sl < 3; sl++) begin
        for (int k = 0; k < (4 >> sl); k++) begin
          off = 10'(g * 4 + (k << sl));
          wd  = {8'(g), 8'(8'h3C ^ (sl << 4) ^ k), 8'(g * 5 + k), 8'(8'hC3 + sl * 3 + k * 17)};
          addr = ((32'hABC00 + 32'(g)) << 10) | 32'(off);
          access(1'b1, 2'(sl), addr, wd, rd);
          nb = 1 << sl;
          for (int b = 0; b < nb; b++)
            exp_mem[int'(off) + b] = wd[8 * (nb - 1 - b) +: 8];
          chk({rf_mem[g*4], rf_mem[g*4+1], rf_mem[g*4+2], rf_mem[g*4+3]} ==
              {exp_mem[g*4], exp_mem[g*4+1], exp_mem[g*4+2], exp_mem[g*4+3]},
              "R7 lanes kept / R5 pieces placed",
              {rf_mem[g*4], rf_mem[g*4+1], rf_mem[g*4+2], rf_mem[g*4+3]},
              {exp_mem[g*4], exp_mem[g*4+1], exp_mem[g*4+2], exp_mem[g*4+3]});
        end
        for (int rs = 0; rs < 3; rs++) begin
          for (int k = 0; k < (4 >> rs); k++) begin
            aoff = 10'(g * 4 + (k << rs));
            off  = aoff | ((g % 2 == 1) ? 10'((1 << rs) - 1) : 10'd0);
            addr = ((32'h5A5A0 ^ 32'(g * 3 + rs)) << 10) | 32'(off);
            access(1'b0, 2'(rs), addr, 32'd0, rd);
            nb = 1 << rs;
            ex = 32'd0;
            for (int b = 0; b < nb; b++) ex = (ex << 8) | 32'(exp_mem[int'(aoff) + b]);
            chk(rd == ex, (g % 2 == 1) ? "R4 R10 R1 read data" : "R4 R1 read data", rd, ex);
          end
        end
      end
    end

    access(1'b0, 2'd2, 32'h0000_0200, 32'd0, rd);
    access(1'b1, 2'd0, 32'h0000_03FF, 32'hFF, rd);
    access(1'b1, 2'd1, 32'hFFFF_F2A0, 32'hBEEF, rd);
    access(1'b0, 2'd0, 32'h0000_1001, 32'd0, rd);
    chk(rd == 32'(exp_mem[1]), "R1 masked offset read", rd, 32'(exp_mem[1]));
    chk(rf_mem[0] == exp_mem[0] && rf_mem[1] == exp_mem[1], "R2 error write ignored",
        {16'd0, rf_mem[0], rf_mem[1]}, {16'd0, exp_mem[0], exp_mem[1]});
    @(negedge clk);
    finish_run();
  end
endmodule